// File: doc/BRIEF.md
# Single-to-Eight-Bit Float Narrowing Converter

This block narrows IEEE single-precision words into one of two eight-bit floating-point formats. A mode input picks the format for each word. One format has a 4-bit exponent and a 3-bit mantissa, and it has no infinity. The other has a 5-bit exponent and a 2-bit mantissa, and it keeps separate infinity and NaN codes. Before encoding, every word is multiplied by a power of two. The block does this by adding a signed scale exponent to the input's exponent, so a quantizer can move a tensor's range into the narrow format without a multiplier.

Words arrive on a valid/ready stream together with their scale and mode. Each result leaves two register stages later as a byte, with an overflow flag and a NaN flag beside it. Rounding is to nearest, with ties going to the even code. Results too small for a normal code come out as subnormals. Values below half the smallest subnormal come out as zero and keep their sign. Values too large for the format become NaN in the 4-bit-exponent mode and infinity in the 5-bit-exponent mode.

Top module: `f8_narrow_conv`

## Requirements
- R1: With fmtSel=0 the output byte is {sign, 4-bit biased exponent (bias 7), 3-bit mantissa}. Example: 1.0 gives 0x38 and -1.0 gives 0xB8.
- R2: With fmtSel=1 the output byte is {sign, 5-bit biased exponent (bias 15), 2-bit mantissa}. Example: 1.0 gives 0x3C, and the largest finite magnitude 57344 gives 0x7B.
- R3: Dropped mantissa bits are rounded to nearest, with ties to the even code, and a carry may roll into the exponent. With fmtSel=0: 1.0625 gives 0x38, 1.1875 gives 0x3A and 1.9375 gives 0x40.
- R4: Results below the smallest normal are encoded with exponent field 0. Magnitudes at or below half of the smallest subnormal become a signed zero. With fmtSel=0: 2^-9 gives 0x01, 1.5*2^-10 gives 0x01, 2^-10 gives 0x00, -2^-10 gives 0x80 and 2^-7 gives 0x04. With fmtSel=1, 2^-16 gives 0x01.
- R5: The input is multiplied by 2^scaleExp (a signed two's-complement value) before encoding. With fmtSel=0, 1.0 with scaleExp=+3 gives 0x50.
- R6: With fmtSel=0 the largest finite magnitude is 448 (0x7E), and 464 rounds down to it. A finite result above that range gives NaN (low seven bits 0x7F, sign kept) with outOvf=1 and outNan=1. For example, 480 gives 0x7F.
- R7: With fmtSel=1 a finite overflow gives signed infinity (low seven bits 0x7C) with outOvf=1 and outNan=0. For example, 61440 gives 0x7C. An infinite input gives infinity with outOvf=0.
- R8: A NaN input gives the format's canonical NaN with the input sign kept: low seven bits 0x7F for fmtSel=0 and 0x7E for fmtSel=1, with outNan=1. With fmtSel=0 an infinite input also gives 0x7F with outNan=1. outOvf is 0 for every non-finite input.
- R9: Subnormal single-precision inputs are normalized before scaling. With fmtSel=0, 0x00400000 (2^-127) with scaleExp=+120 gives 0x04.
- R10: A word accepted at a clock edge shows on outValid after the second following edge. While outValid is high and outReady is low, both stages hold, inReady is low, and outByte, outOvf and outNan stay unchanged.
- R11: During and right after reset, outValid is 0 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word is present |
| inReady | output | 1 | Block accepts a word at this edge |
| inWord | input | 32 | Single-precision input |
| scaleExp | input | SCALE_W | Signed power-of-two scale exponent |
| fmtSel | input | 1 | 0: 4-bit exponent format, 1: 5-bit exponent format |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result |
| outByte | output | 8 | Eight-bit encoded result |
| outOvf | output | 1 | Finite value exceeded the format range |
| outNan | output | 1 | Output code is a NaN |

## Verification
Rounding and the range check can act on the same word, and their results can point different ways. The 464 and 480 cases probe where a rounding carry meets the overflow limit: one rounds down to the largest finite code, while the other rounds up past that code into NaN with both flags set. The 61440 case repeats this in the 5-bit-exponent mode, where the carry has to produce infinity instead. Back-pressure and a new word arriving also meet in one cycle, and a stalled burst checks that the held result stays stable and that the blocked word is not taken.

// File: rtl/f8n_pkg.sv
package f8n_pkg;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
  } pipeStrobes_t;

  typedef enum logic [1:0] {
    CLS_FIN  = 2'd0,
    CLS_ZERO = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } valClass_t;

endpackage

// File: rtl/f8n_ctrl.sv
module f8n_ctrl
  import f8n_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output pipeStrobes_t strobes
);

  logic v1, v2;
  logic advance;

  // one enable for both stages: a stall freezes the whole pipe
  assign advance = !v2 || outReady;
  assign inReady = advance;
  assign outValid = v2;
  assign strobes.s1Load = advance && inValid;
  assign strobes.s2Load = advance && v1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (advance) begin
      v1 <= inValid;
      v2 <= v1;
    end
  end

endmodule

// File: rtl/f8n_dpath.sv
module f8n_dpath
  import f8n_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pipeStrobes_t              strobes,
  input  logic [31:0]               inWord,
  input  logic signed [SCALE_W-1:0] scaleExp,
  input  logic                      fmtSel,
  output logic [7:0]                outByte,
  output logic                      outOvf,
  output logic                      outNan
);

  localparam int EXP_W = ((SCALE_W > 9) ? SCALE_W : 9) + 2;
  localparam int SIG_W = 24;

  // ---------------- stage 1: classify, normalize, scale ----------------
  logic            sgnIn;
  logic [7:0]      eIn;
  logic [22:0]     fIn;
  logic [4:0]      msbPos;
  valClass_t       cls1;
  logic [SIG_W-1:0] sig1;
  int              expU, expScaled;

  assign sgnIn = inWord[31];
  assign eIn   = inWord[30:23];
  assign fIn   = inWord[22:0];

  always_comb begin
    msbPos = '0;
    for (int i = 0; i < 23; i++) if (fIn[i]) msbPos = 5'(i);
    cls1 = CLS_FIN;
    sig1 = '0;
    expU = 0;
    if (eIn == 8'hFF) begin
      cls1 = (fIn != '0) ? CLS_NAN : CLS_INF;
    end else if (eIn == 8'h00 && fIn == '0) begin
      cls1 = CLS_ZERO;
    end else if (eIn == 8'h00) begin
      sig1 = SIG_W'({1'b0, fIn} << (5'd23 - msbPos));
      expU = int'(msbPos) - 149;
    end else begin
      sig1 = {1'b1, fIn};
      expU = int'(eIn) - 127;
    end
    expScaled = expU + int'(scaleExp);
  end

  logic                    r1Sgn, r1Fmt;
  valClass_t               r1Cls;
  logic [SIG_W-1:0]        r1Sig;
  logic signed [EXP_W-1:0] r1Exp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r1Sgn <= 1'b0;
      r1Fmt <= 1'b0;
      r1Cls <= CLS_ZERO;
      r1Sig <= '0;
      r1Exp <= '0;
    end else if (strobes.s1Load) begin
      r1Sgn <= sgnIn;
      r1Fmt <= fmtSel;
      r1Cls <= cls1;
      r1Sig <= sig1;
      r1Exp <= EXP_W'(expScaled);
    end
  end

  // ---------------- stage 2: round and encode ----------------
  int               mantBits, bias, expI, deficit, shAmt, bEff, mag, maxMag;
  logic [2*SIG_W-1:0] ext;
  logic [SIG_W-1:0] kept, rnd;
  logic             guardBit, stickyBit, roundUp;
  logic [6:0]       code2;
  logic             ovf2, nan2;

  always_comb begin
    mantBits = r1Fmt ? 2 : 3;
    bias     = r1Fmt ? 15 : 7;
    maxMag   = r1Fmt ? 123 : 126;
    expI     = int'(r1Exp);
    deficit  = (1 - bias) - expI;
    if (deficit < 0) deficit = 0;
    shAmt = 23 - mantBits + deficit;
    if (shAmt > 31) shAmt = 31;
    ext       = {r1Sig, {SIG_W{1'b0}}} >> shAmt;
    kept      = ext[2*SIG_W-1:SIG_W];
    guardBit  = ext[SIG_W-1];
    stickyBit = |ext[SIG_W-2:0];
    roundUp   = guardBit && (stickyBit || kept[0]);
    rnd       = kept + SIG_W'(roundUp);
    // hidden bit of rnd lands in the exponent field; a carry rolls on
    bEff = expI + bias - 1;
    if (bEff < 0) bEff = 0;
    mag = (bEff << mantBits) + int'(rnd);
    code2 = '0;
    ovf2  = 1'b0;
    nan2  = 1'b0;
    unique case (r1Cls)
      CLS_NAN: begin
        code2 = r1Fmt ? 7'h7E : 7'h7F;
        nan2  = 1'b1;
      end
      CLS_INF: begin
        code2 = r1Fmt ? 7'h7C : 7'h7F;
        nan2  = !r1Fmt;
      end
      CLS_ZERO: code2 = '0;
      default: begin
        if (mag > maxMag) begin
          ovf2  = 1'b1;
          code2 = r1Fmt ? 7'h7C : 7'h7F;
          nan2  = !r1Fmt;
        end else begin
          code2 = 7'(mag);
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outByte <= '0;
      outOvf  <= 1'b0;
      outNan  <= 1'b0;
    end else if (strobes.s2Load) begin
      outByte <= {r1Sgn, code2};
      outOvf  <= ovf2;
      outNan  <= nan2;
    end
  end

endmodule

// File: rtl/f8_narrow_conv.sv
module f8_narrow_conv
  import f8n_pkg::*;
#(
  parameter int SCALE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic [31:0]               inWord,
  input  logic signed [SCALE_W-1:0] scaleExp,
  input  logic                      fmtSel,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [7:0]                outByte,
  output logic                      outOvf,
  output logic                      outNan
);

  pipeStrobes_t strobes;

  f8n_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  f8n_dpath #(.SCALE_W(SCALE_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inWord   (inWord),
    .scaleExp (scaleExp),
    .fmtSel   (fmtSel),
    .outByte  (outByte),
    .outOvf   (outOvf),
    .outNan   (outNan)
  );

endmodule

// File: rtl/f8n_chk.sv
module f8n_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outByte,
  input logic       outOvf,
  input logic       outNan
);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outByte) && $stable(outOvf) && $stable(outNan)));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  p_idle_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  p_nan_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outNan) |-> (outByte[6:0] == 7'h7F || (outByte[6:2] == 5'h1F && outByte[1:0] != 2'b00)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOvf && outNan) |-> (outByte[6:0] == 7'h7F));

  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outOvf && !outNan) |-> (outByte[6:0] == 7'h7C));

endmodule

bind f8_narrow_conv f8n_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outByte  (outByte),
  .outOvf   (outOvf),
  .outNan   (outNan)
);

// File: tb/f8_narrow_conv_tb.sv
`timescale 1ns/1ps
module f8_narrow_conv_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [31:0]       inWord = '0;
  logic signed [7:0] scaleExp = '0;
  logic              fmtSel = 1'b0;
  logic              outValid;
  logic              outReady = 1'b1;
  logic [7:0]        outByte;
  logic              outOvf, outNan;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  f8_narrow_conv #(.SCALE_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord(inWord), .scaleExp(scaleExp), .fmtSel(fmtSel),
    .outValid(outValid), .outReady(outReady), .outByte(outByte),
    .outOvf(outOvf), .outNan(outNan)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // send one word into an empty pipe, check result two edges later
  task automatic convOne(string tag, logic [31:0] w, int sc, logic fmt,
                         logic [7:0] expByte, logic expOvf, logic expNan);
    @(negedge clk);
    outReady = 1'b1;
    inValid  = 1'b1;
    inWord   = w;
    scaleExp = 8'(sc);
    fmtSel   = fmt;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 32'(outValid), 32'd1);
    check({tag, " byte"}, 32'(outByte), 32'(expByte));
    check({tag, " flags"}, {30'd0, outOvf, outNan}, {30'd0, expOvf, expNan});
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R11 outValid in reset", 32'(outValid), 32'd0);
    check("R11 inReady in reset", 32'(inReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 outValid after reset", 32'(outValid), 32'd0);
    check("R11 inReady after reset", 32'(inReady), 32'd1);
  endtask

  task automatic testE4m3Basic;
    convOne("R1 one", 32'h3F800000, 0, 1'b0, 8'h38, 1'b0, 1'b0);
    convOne("R1 minus one", 32'hBF800000, 0, 1'b0, 8'hB8, 1'b0, 1'b0);
    convOne("R1 zero neg", 32'h80000000, 0, 1'b0, 8'h80, 1'b0, 1'b0);
  endtask

  task automatic testE5m2Basic;
    convOne("R2 one", 32'h3F800000, 0, 1'b1, 8'h3C, 1'b0, 1'b0);
    convOne("R2 max 57344", 32'h47600000, 0, 1'b1, 8'h7B, 1'b0, 1'b0);
  endtask

  task automatic testRounding;
    convOne("R3 tie even down", 32'h3F880000, 0, 1'b0, 8'h38, 1'b0, 1'b0);
    convOne("R3 tie even up", 32'h3F980000, 0, 1'b0, 8'h3A, 1'b0, 1'b0);
    convOne("R3 carry exponent", 32'h3FF80000, 0, 1'b0, 8'h40, 1'b0, 1'b0);
  endtask

  task automatic testSubnormal;
    convOne("R4 min sub", 32'h3F800000, -9, 1'b0, 8'h01, 1'b0, 1'b0);
    convOne("R4 round to min sub", 32'h3FC00000, -10, 1'b0, 8'h01, 1'b0, 1'b0);
    convOne("R4 half min to zero", 32'h3F800000, -10, 1'b0, 8'h00, 1'b0, 1'b0);
    convOne("R4 neg to neg zero", 32'hBF800000, -10, 1'b0, 8'h80, 1'b0, 1'b0);
    convOne("R4 e5m2 min sub", 32'h3F800000, -16, 1'b1, 8'h01, 1'b0, 1'b0);
  endtask

  task automatic testScale;
    convOne("R5 scale plus3", 32'h3F800000, 3, 1'b0, 8'h50, 1'b0, 1'b0);
  endtask

  task automatic testE4m3Range;
    convOne("R6 max 448", 32'h43E00000, 0, 1'b0, 8'h7E, 1'b0, 1'b0);
    convOne("R6 464 ties down", 32'h43E80000, 0, 1'b0, 8'h7E, 1'b0, 1'b0);
    convOne("R6 480 overflow", 32'h43F00000, 0, 1'b0, 8'h7F, 1'b1, 1'b1);
    convOne("R6 neg overflow scaled", 32'hBF800000, 20, 1'b0, 8'hFF, 1'b1, 1'b1);
  endtask

  task automatic testE5m2Range;
    convOne("R7 61440 to inf", 32'h47700000, 0, 1'b1, 8'h7C, 1'b1, 1'b0);
    convOne("R7 inf in", 32'hFF800000, 0, 1'b1, 8'hFC, 1'b0, 1'b0);
  endtask

  task automatic testSpecials;
    convOne("R8 nan e4m3", 32'h7FC00000, 0, 1'b0, 8'h7F, 1'b0, 1'b1);
    convOne("R8 neg nan e5m2", 32'hFFC00000, 0, 1'b1, 8'hFE, 1'b0, 1'b1);
    convOne("R8 inf e4m3", 32'h7F800000, 0, 1'b0, 8'h7F, 1'b0, 1'b1);
  endtask

  task automatic testDenormIn;
    convOne("R9 fp32 subnormal", 32'h00400000, 120, 1'b0, 8'h04, 1'b0, 1'b0);
  endtask

  task automatic testBackpressure;
    @(negedge clk);
    outReady = 1'b0;
    inValid  = 1'b1;
    inWord   = 32'h3F800000;
    scaleExp = '0;
    fmtSel   = 1'b0;
    @(posedge clk);
    @(negedge clk);
    inWord = 32'hBF800000;
    fmtSel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inWord = 32'h43E00000;
    fmtSel = 1'b0;
    check("R10 stall inReady low", 32'(inReady), 32'd0);
    check("R10 stall first out", {23'd0, outValid, outByte}, {23'd0, 1'b1, 8'h38});
    @(posedge clk);
    @(negedge clk);
    check("R10 stall held", {23'd0, outValid, outByte}, {23'd0, 1'b1, 8'h38});
    inValid  = 1'b0;
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 second out", {23'd0, outValid, outByte}, {23'd0, 1'b1, 8'hBC});
    @(posedge clk);
    @(negedge clk);
    check("R10 drained, blocked word not taken", 32'(outValid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testE4m3Basic();
    testE5m2Basic();
    testRounding();
    testSubnormal();
    testScale();
    testE4m3Range();
    testE5m2Range();
    testSpecials();
    testDenormIn();
    testBackpressure();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule